// File: doc/BRIEF.md
# Single-Shot Comparator Control Bank

This block holds a small bank of control entries. Each entry watches a chosen set of comparator match lines and raises a one-cycle fire pulse when one of them hits. There are eight address-range match lines and sixteen single-address match lines. An entry in one-shot mode fires on its first qualifying match and then stays silent until software clears its sticky fired flag. An entry in repeating mode fires on every cycle that has a qualifying match. The comparators themselves live outside this block and only their match vectors come in.

Software programs each entry through an indexed write port and reads it back through a separate combinational read port. The register image is 64 bits wide. Bits 15..0 select single-address comparators, bits 23..16 select address-range comparators, and bit 24 chooses the firing mode. All higher bits are dropped on write and read as zero. The block accepts a write only while the trace unit reports idle and only for an entry index that exists. A refused write leaves the bank unchanged and produces a one-cycle error pulse.

Top module: `shot_ctl_bank`

## Requirements
- R1: While reset is low at a clock edge, every entry's configuration, every fired flag, every fire pulse and the write-error flag become zero.
- R2: A write with `idle` high and `wr_idx` below NUM_ENTRIES stores bits 24..0 of `wr_data` at the clock edge. `rd_data` for that index then returns those bits, with bits 63..25 reading as zero.
- R3: A write with `idle` low changes no entry, and `wr_err` is high for exactly the one cycle after that write.
- R4: A write with `wr_idx` at or above NUM_ENTRIES changes no entry and pulses `wr_err` the next cycle. A read of such an index returns zero and drives `rd_bad` high.
- R5: An entry's raw match in a cycle is the OR of (bits 23..16 AND `range_hit`) and (bits 15..0 AND `addr_hit`). Hits on unselected lines never fire the entry.
- R6: With bit 24 clear (one-shot), a raw match produces a `fire` pulse only when the entry's fired flag is clear. After that, further matches give no pulse until the flag is cleared.
- R7: With bit 24 set (repeating), every cycle with a raw match produces a `fire` pulse in the next cycle.
- R8: Every raw match sets the entry's sticky `fired` flag. The flag stays set until the entry's bit of `stat_clr` is high at a clock edge.
- R9: When clear and raw match arrive in the same cycle, the clear is applied first. The entry fires even in one-shot mode and its flag ends up set.
- R10: `fire` and `fired` update at the clock edge that samples the match. Each entry acts independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle | input | 1 | Trace unit is idle; writes allowed |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Entry index for write |
| wr_data | input | 64 | Write data image |
| rd_idx | input | IDX_W | Entry index for read |
| rd_data | output | 64 | Read image of the selected entry |
| rd_bad | output | 1 | Read index is not implemented |
| wr_err | output | 1 | One-cycle pulse after a refused write |
| range_hit | input | 8 | Address-range comparator match lines |
| addr_hit | input | 16 | Single-address comparator match lines |
| stat_clr | input | NUM_ENTRIES | Per-entry fired-flag clear |
| fire | output | NUM_ENTRIES | Per-entry fire pulse |
| fired | output | NUM_ENTRIES | Per-entry sticky fired flag |

## Verification
The bench goes after the one-shot entry that keeps matching. A design that ignored the sticky flag would pulse every cycle, just like a repeating entry. It then lands a clear on the same cycle as a match. A design that gave the clear priority would miss the pulse or leave the flag clear. Writes are tried while busy and at indexes 6 and 7 with six entries. A design that let them through would change a later read-back or fire, and one that dropped the error would leave `wr_err` low. Hits on unselected lines and a long pseudo-random phase with toggling idle catch a wrong mask bit, a swapped field or a mode bit read from the wrong position.

// File: rtl/shot_ctl_pkg.sv
// Package: shared field layout and helpers for the shot control bank.
// Assumes the 64-bit register image with mode at bit 24, range mask at 23..16
// and single-address mask at 15..0.
package shot_ctl_pkg;
    localparam int REG_W    = 64;
    localparam int RANGE_N  = 8;
    localparam int SINGLE_N = 16;
    localparam int MODE_BIT = RANGE_N + SINGLE_N;
    localparam int USED_W   = MODE_BIT + 1;

    typedef struct packed {
        logic                repeat_mode;
        logic [RANGE_N-1:0]  range_sel;
        logic [SINGLE_N-1:0] single_sel;
    } shot_cfg_t;

    // Turn a software image into a configuration, dropping reserved bits.
    function automatic shot_cfg_t cfg_from_image(input logic [REG_W-1:0] img);
        shot_cfg_t c;
        c.repeat_mode = img[MODE_BIT];
        c.range_sel   = img[SINGLE_N +: RANGE_N];
        c.single_sel  = img[0 +: SINGLE_N];
        return c;
    endfunction

    // Turn a configuration back into a software image with reserved bits zero.
    function automatic logic [REG_W-1:0] image_from_cfg(input shot_cfg_t c);
        logic [REG_W-1:0] img;
        img = '0;
        img[USED_W-1:0] = c;
        return img;
    endfunction
endpackage

// File: rtl/shot_access_guard.sv
// Module: decides whether a write may land and flags refused writes.
// Assumes wr_idx/rd_idx are wide enough to express indexes beyond NUM_ENTRIES.
module shot_access_guard #(
    parameter int NUM_ENTRIES = 6,
    parameter int IDX_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             wr_ok,
    output logic             rd_bad,
    output logic             wr_err
);
    logic wr_idx_bad;

    // Range check of both indexes and the write permission.
    always_comb begin
        wr_idx_bad = (int'(wr_idx) >= NUM_ENTRIES);
        rd_bad     = (int'(rd_idx) >= NUM_ENTRIES);
        wr_ok      = wr_en && idle && !wr_idx_bad;
    end

    // One-cycle error pulse after a refused write.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_err <= 1'b0;
        else        wr_err <= wr_en && (!idle || wr_idx_bad);
    end
endmodule

// File: rtl/shot_cfg_slot.sv
// Module: configuration storage for one entry.
// Assumes wr_ok is already qualified by idle and index range.
module shot_cfg_slot
    import shot_ctl_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int SLOT  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_data,
    output shot_cfg_t        cfg
);
    // Load the entry when an accepted write names this slot.
    always_ff @(posedge clk) begin
        if (!rst_n)                                cfg <= '0;
        else if (wr_ok && int'(wr_idx) == SLOT)    cfg <= cfg_from_image(wr_data);
    end
endmodule

// File: rtl/shot_engine.sv
// Module: match qualification, fire pulse and sticky flag for one entry.
// Assumes match vectors are synchronous to clk; clear takes effect before a same-cycle set.
module shot_engine
    import shot_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  shot_cfg_t           cfg,
    input  logic [RANGE_N-1:0]  range_hit,
    input  logic [SINGLE_N-1:0] addr_hit,
    input  logic                clr,
    output logic                fire,
    output logic                fired
);
    logic raw;
    logic armed;

    // Raw match and whether the entry may pulse this cycle.
    always_comb begin
        raw   = (|(cfg.range_sel & range_hit)) || (|(cfg.single_sel & addr_hit));
        armed = cfg.repeat_mode || !fired || clr;
    end

    // Register the pulse and update the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire  <= 1'b0;
            fired <= 1'b0;
        end else begin
            fire  <= raw && armed;
            fired <= (fired && !clr) || raw;
        end
    end
endmodule

// File: rtl/shot_ctl_bank.sv
// Module: top of the shot control bank; one slot and one engine per entry,
// plus the access guard and a read multiplexer.
// Assumes NUM_ENTRIES <= 2**IDX_W and NUM_ENTRIES <= 8.
module shot_ctl_bank
    import shot_ctl_pkg::*;
#(
    parameter int NUM_ENTRIES = 6,
    parameter int IDX_W       = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idle,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic [63:0]            wr_data,
    input  logic [IDX_W-1:0]       rd_idx,
    output logic [63:0]            rd_data,
    output logic                   rd_bad,
    output logic                   wr_err,
    input  logic [7:0]             range_hit,
    input  logic [15:0]            addr_hit,
    input  logic [NUM_ENTRIES-1:0] stat_clr,
    output logic [NUM_ENTRIES-1:0] fire,
    output logic [NUM_ENTRIES-1:0] fired
);
    localparam int CFG_W = $bits(shot_cfg_t);

    logic                         wr_ok;
    shot_cfg_t                    cfg_arr [NUM_ENTRIES];
    logic [NUM_ENTRIES*CFG_W-1:0] cfg_flat;
    logic [NUM_ENTRIES-1:0]       mode_vec;

    shot_access_guard #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .idle(idle), .wr_en(wr_en),
        .wr_idx(wr_idx), .rd_idx(rd_idx),
        .wr_ok(wr_ok), .rd_bad(rd_bad), .wr_err(wr_err)
    );

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        shot_cfg_slot #(.IDX_W(IDX_W), .SLOT(e)) u_slot (
            .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok),
            .wr_idx(wr_idx), .wr_data(wr_data), .cfg(cfg_arr[e])
        );
        shot_engine u_eng (
            .clk(clk), .rst_n(rst_n), .cfg(cfg_arr[e]),
            .range_hit(range_hit), .addr_hit(addr_hit), .clr(stat_clr[e]),
            .fire(fire[e]), .fired(fired[e])
        );
        assign cfg_flat[e*CFG_W +: CFG_W] = cfg_arr[e];
        assign mode_vec[e]                = cfg_arr[e].repeat_mode;
    end

    // Read multiplexer; an unimplemented index reads as zero.
    always_comb begin
        rd_data = '0;
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (int'(rd_idx) == e) rd_data = image_from_cfg(cfg_arr[e]);
        end
    end
endmodule

// File: rtl/shot_ctl_bank_chk.sv
// Module: property checker for the shot control bank, attached by bind.
// Assumes it sees the top's ports plus its flattened configuration and mode vector.
module shot_ctl_bank_chk #(
    parameter int NUM_ENTRIES = 6,
    parameter int IDX_W       = 3,
    parameter int CFG_W       = 25
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         idle,
    input logic                         wr_en,
    input logic [IDX_W-1:0]             wr_idx,
    input logic [63:0]                  rd_data,
    input logic                         rd_bad,
    input logic                         wr_err,
    input logic [7:0]                   range_hit,
    input logic [15:0]                  addr_hit,
    input logic [NUM_ENTRIES-1:0]       stat_clr,
    input logic [NUM_ENTRIES-1:0]       fire,
    input logic [NUM_ENTRIES-1:0]       fired,
    input logic [NUM_ENTRIES-1:0]       mode_vec,
    input logic [NUM_ENTRIES*CFG_W-1:0] cfg_flat
);
    AST_RES0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[63:25] == '0);                                          // R2

    AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idle) |=> wr_err);                                   // R3

    AST_BUSY_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !idle) |=> $stable(cfg_flat));                        // R3

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en));                                       // R3

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bad |-> (rd_data == '0));                                    // R4

    AST_BAD_INDEX_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_idx) >= NUM_ENTRIES) |=> wr_err);             // R4

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_prop
        AST_FIRE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
            fire[e] |-> $past((|range_hit) || (|addr_hit)));            // R5

        AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
            (fire[e] && !$past(mode_vec[e])) |->
                (!$past(fired[e]) || $past(stat_clr[e])));              // R6

        AST_FIRE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            fire[e] |-> fired[e]);                                      // R8

        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(fired[e]) && !$past(stat_clr[e])) |-> fired[e]);     // R8
    end
endmodule

bind shot_ctl_bank shot_ctl_bank_chk #(
    .NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W), .CFG_W(CFG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .idle(idle), .wr_en(wr_en), .wr_idx(wr_idx),
    .rd_data(rd_data), .rd_bad(rd_bad), .wr_err(wr_err),
    .range_hit(range_hit), .addr_hit(addr_hit), .stat_clr(stat_clr),
    .fire(fire), .fired(fired), .mode_vec(mode_vec), .cfg_flat(cfg_flat)
);

// File: tb/sim_shot_ctl_bank.sv
// Bench: behavioural reference model compared against the design on every clock.
module sim_shot_ctl_bank;
    localparam int N     = 6;
    localparam int IDX_W = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          idle;
    logic          wr_en;
    logic [2:0]    wr_idx;
    logic [63:0]   wr_data;
    logic [2:0]    rd_idx;
    logic [63:0]   rd_data;
    logic          rd_bad;
    logic          wr_err;
    logic [7:0]    range_hit;
    logic [15:0]   addr_hit;
    logic [N-1:0]  stat_clr;
    logic [N-1:0]  fire;
    logic [N-1:0]  fired;

    // Reference state
    logic [63:0]   m_cfg [8];
    logic [N-1:0]  m_fire;
    logic [N-1:0]  m_stat;
    logic          m_err;

    int vectors = 0;
    int bad     = 0;
    string req  = "R1";

    always #4 clk = ~clk;   // 125 MHz

    shot_ctl_bank #(.NUM_ENTRIES(N), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst_n(rst_n), .idle(idle), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .rd_bad(rd_bad),
        .wr_err(wr_err), .range_hit(range_hit), .addr_hit(addr_hit),
        .stat_clr(stat_clr), .fire(fire), .fired(fired)
    );

    task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare at the falling edge.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) m_cfg[k] = '0;
            m_fire = '0; m_stat = '0; m_err = 1'b0;
        end else begin
            for (int k = 0; k < N; k++) begin
                bit hit;
                hit = ((m_cfg[k][23:16] & range_hit) != 0) || ((m_cfg[k][15:0] & addr_hit) != 0);
                m_fire[k] = hit && (m_cfg[k][24] || !m_stat[k] || stat_clr[k]);
                m_stat[k] = (m_stat[k] && !stat_clr[k]) || hit;
            end
            m_err = wr_en && (!idle || int'(wr_idx) >= N);
            if (wr_en && idle && int'(wr_idx) < N)
                m_cfg[wr_idx] = wr_data & 64'h0000_0000_01FF_FFFF;
        end
        @(negedge clk);
        check("fire",   64'(fire),   64'(m_fire));
        check("fired",  64'(fired),  64'(m_stat));
        check("wr_err", 64'(wr_err), 64'(m_err));
        check("rd_bad", 64'(rd_bad), 64'(int'(rd_idx) >= N));
        check("rd_data", rd_data, (int'(rd_idx) < N) ? m_cfg[rd_idx] : 64'h0);
    endtask

    task automatic wr(input int idx, input logic [63:0] d);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic quiet(input int n);
        range_hit = '0; addr_hit = '0; stat_clr = '0;
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        rst_n = 1'b0; idle = 1'b1; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        rd_idx = '0; range_hit = '0; addr_hit = '0; stat_clr = '0;
        req = "R1";
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R2: full image readback keeps only bits 24..0
        req = "R2";
        rd_idx = 3'd0;
        wr(0, 64'hFFFF_FFFF_FFFF_FFFF);
        step();
        wr(0, 64'h0000_0000_0004_0000);           // range 2, one-shot
        wr(1, 64'h0000_0000_0100_0020);           // single 5, repeating
        wr(2, 64'h0000_0000_0080_8000);           // range 7 + single 15, one-shot
        wr(5, 64'hABCD_0000_0100_0001);           // single 0, repeating
        for (int k = 0; k < 8; k++) begin rd_idx = 3'(k); step(); end

        // R4: unimplemented indexes
        req = "R4";
        wr(6, 64'h0000_0000_0000_FFFF);
        wr(7, 64'h0000_0000_00FF_0000);
        rd_idx = 3'd6; step();
        rd_idx = 3'd7; step();

        // R3: busy write is refused
        req = "R3";
        idle = 1'b0; rd_idx = 3'd3;
        wr(3, 64'h0000_0000_0000_0004);
        step();
        addr_hit = 16'h0004; step();
        idle = 1'b1; quiet(1);

        // R5: hits on unselected lines never fire
        req = "R5";
        range_hit = 8'h7B; addr_hit = 16'h7FDE; step(); step();
        quiet(1);

        // R6: one-shot entry 0 held matching fires once
        req = "R6";
        range_hit = 8'h04; repeat (4) step();
        quiet(2);

        // R7: repeating entry 1 fires every matching cycle
        req = "R7";
        addr_hit = 16'h0020; repeat (4) step();
        quiet(1);

        // R8: clear re-arms entry 0
        req = "R8";
        stat_clr = 6'b000001; step();
        quiet(1);
        range_hit = 8'h04; step(); step();
        quiet(1);

        // R9: clear and match in the same cycle
        req = "R9";
        range_hit = 8'h04; stat_clr = 6'b000001; step();
        stat_clr = '0; step();
        quiet(1);

        // R10: independent entries, entry 2 via single 15, entry 5 via single 0
        req = "R10";
        addr_hit = 16'h8001; step(); step();
        range_hit = 8'h80; addr_hit = '0; step();
        quiet(1);
        stat_clr = '1; step();
        quiet(1);

        // Mixed pseudo-random phase across all behaviours
        req = "R7";
        lfsr = 32'h1ACE_B00C;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            idle      = lfsr[3] | lfsr[9];
            wr_en     = (lfsr[7:4] == 4'h5);
            wr_idx    = lfsr[12:10];
            wr_data   = {lfsr, lfsr ^ 32'h5A5A_0F0F};
            rd_idx    = lfsr[15:13];
            range_hit = (lfsr[16]) ? lfsr[24:17] : 8'h0;
            addr_hit  = (lfsr[25]) ? lfsr[31:16] : 16'h0;
            stat_clr  = (lfsr[2:0] == 3'd0) ? lfsr[N+8:9] : '0;
            step();
        end
        wr_en = 1'b0;
        quiet(2);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end
endmodule